// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block carries out one bit-level bus operation at a time on a shared, open-drain two-wire bus. The four operations are a start condition, a stop condition, one data bit out, and one data bit in. A byte-level sequencer above it issues a command with a one-cycle `cmd_valid` strobe and waits for the one-cycle `cmd_ack`. Reading a byte therefore takes eight read commands in a row. Every operation runs through four equal phases. Each phase lasts `prescale + 1` clock cycles, so a programmable 16-bit divider sets the bus rate.

The clock and data lines are never driven high. Each has an output value that is tied low and an active-low output enable. Letting go of a line leaves it to the external pull-up. The pad levels come back through a two-flop synchroniser, which feeds start and stop detection. That detection maintains a bus-busy flag. The same synchronised levels let the engine see when another master wins the bus: it then drops both lines, goes back to idle and raises a sticky arbitration-lost flag.

The state machine has seventeen states. `ST_IDLE` waits for a command. Each command then has its own chain of four states: `ST_STA_A..D`, `ST_STP_A..D`, `ST_WR_A..D` and `ST_RD_A..D`. The transitions are as follows:
- An accepted command moves `ST_IDLE` to the A state of its chain.
- A phase-timer tick moves A to B, B to C, C to D, and D back to `ST_IDLE`.
- A loss of arbitration moves any state to `ST_IDLE` and takes priority over every other transition.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both output enables are high (lines released), and `cmd_ack`, `rx_bit`, `bus_busy` and `arb_lost` are low.
- R2: A command is accepted when `cmd_valid` is high, the engine is idle and `enable` is high. The command codes on `cmd` are: 0 start, 1 stop, 2 write, 3 read. Each phase lasts `prescale`+1 cycles. `cmd_ack` is high for exactly one cycle, which begins 4*(`prescale`+1) cycles after the accepting edge, and the same cycle is also the first cycle back in idle.
- R3: Start sets the releases (clock, data) phase by phase as follows: A (held, released), B (released, released), C (released, low), D (low, low). "Held" means the clock keeps its level from before the command.
- R4: Stop: A (low, low), B (released, low), C (released, released), D (released, released).
- R5: Write with data bit d: the clock is low in A, released in B and C, and low in D. The data line carries d (1 = released) through all four phases.
- R6: Read: the data line is released in all phases, and the clock follows the write pattern. `rx_bit` takes the synchronised data level at the end of phase B and holds it afterwards.
- R7: While `enable` is low, no command is accepted, the phase timer does not advance and both output enables keep their values.
- R8: The synchronised pads drive bus detection. A data fall while the clock is high sets `bus_busy`, and a data rise while the clock is high clears it. This applies whichever master caused the condition.
- R9: In write phase C, if the data line is released but reads low while the clock reads high, arbitration is lost. This takes priority over the phase tick. It releases both lines, returns the engine to idle with no `cmd_ack`, and sets `arb_lost`.
- R10: A stop detected while no own stop is pending also sets `arb_lost`. An own stop stays pending from its acceptance until the next detected start. `arb_lost` stays set until the next accepted command.
- R11: `scl_o` and `sda_o` are always 0. An output enable at 0 pulls its line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low freezes the engine |
| prescale | input | 16 | Phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | Command code: 0 start, 1 stop, 2 write, 3 read |
| tx_bit | input | 1 | Bit to send for a write |
| scl_in | input | 1 | Clock pad level |
| sda_in | input | 1 | Data pad level |
| cmd_ack | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Bit captured by the last read |
| scl_o | output | 1 | Clock drive value (always 0) |
| scl_oe_n | output | 1 | Clock output enable, active low |
| sda_o | output | 1 | Data drive value (always 0) |
| sda_oe_n | output | 1 | Data output enable, active low |
| bus_busy | output | 1 | Bus held between a start and a stop |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
The end of phase C in a write and a loss of arbitration can land in the same cycle. The test provokes this with a prescale of 3 and a second master that pulls the data line low part-way through phase C. The timing is chosen so that the synchronised low level first shows in the last cycle of the phase, which is the cycle of the tick. The result is correct if the engine never reaches phase D: at the point where D would begin, both lines are released, `arb_lost` is set, and no `cmd_ack` appears afterwards.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bit_cmd_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_STA_A, ST_STA_B, ST_STA_C, ST_STA_D,
        ST_STP_A, ST_STP_B, ST_STP_C, ST_STP_D,
        ST_WR_A,  ST_WR_B,  ST_WR_C,  ST_WR_D,
        ST_RD_A,  ST_RD_B,  ST_RD_C,  ST_RD_D
    } phase_state_e;

endpackage

// File: rtl/i2cb_line_sync.sv
module i2cb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pad,
    input  logic sda_pad,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_pipe, sda_pipe;
    logic         scl_d, sda_d;

    // Shift registers idle high, matching a pulled-up bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= (scl_pipe << 1) | STAGES'(scl_pad);
            sda_pipe <= (sda_pipe << 1) | STAGES'(sda_pad);
            scl_d    <= scl_pipe[MSB];
            sda_d    <= sda_pipe[MSB];
        end
    end

    assign scl_s     = scl_pipe[MSB];
    assign sda_s     = sda_pipe[MSB];
    // Data edges while the clock stays high mark bus conditions.
    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

endmodule

// File: rtl/i2cb_phase_timer.sv
module i2cb_phase_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load,
    input  logic [WIDTH-1:0] prescale,
    output logic             tick
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= prescale;
        end else if (enable) begin
            if (cnt_q == '0) cnt_q <= prescale;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = enable && !load && (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2cb_pkg::*;
#(
    parameter int PRESCALE_W  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd,
    input  logic                  tx_bit,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  cmd_ack,
    output logic                  rx_bit,
    output logic                  scl_o,
    output logic                  scl_oe_n,
    output logic                  sda_o,
    output logic                  sda_oe_n,
    output logic                  bus_busy,
    output logic                  arb_lost
);
    phase_state_e state_q, state_d;
    bit_cmd_e     cmd_e;

    logic scl_s, sda_s, start_det, stop_det, tick;
    logic accept, lost_now, in_last_phase, tx_now;
    logic scl_rel_q, sda_rel_q, tx_q, ack_q, rx_q, busy_q, lost_q, stop_exp_q;

    assign cmd_e = bit_cmd_e'(cmd);

    i2cb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pad   (scl_in),
        .sda_pad   (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cb_phase_timer #(.WIDTH(PRESCALE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .load     (accept),
        .prescale (prescale),
        .tick     (tick)
    );

    assign in_last_phase = (state_q == ST_STA_D) || (state_q == ST_STP_D) ||
                           (state_q == ST_WR_D)  || (state_q == ST_RD_D);

    // Lost bus: own released data bit read low in the clock-high window,
    // or a stop condition nobody here asked for.
    assign lost_now = enable &&
        (((state_q == ST_WR_C) && sda_rel_q && scl_s && !sda_s) ||
         (stop_det && !stop_exp_q));

    assign tx_now = accept ? tx_bit : tx_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && cmd_valid) begin
                    accept = 1'b1;
                    unique case (cmd_e)
                        BC_START: state_d = ST_STA_A;
                        BC_STOP:  state_d = ST_STP_A;
                        BC_WRITE: state_d = ST_WR_A;
                        BC_READ:  state_d = ST_RD_A;
                    endcase
                end
            end
            ST_STA_A: if (tick) state_d = ST_STA_B;
            ST_STA_B: if (tick) state_d = ST_STA_C;
            ST_STA_C: if (tick) state_d = ST_STA_D;
            ST_STA_D: if (tick) state_d = ST_IDLE;
            ST_STP_A: if (tick) state_d = ST_STP_B;
            ST_STP_B: if (tick) state_d = ST_STP_C;
            ST_STP_C: if (tick) state_d = ST_STP_D;
            ST_STP_D: if (tick) state_d = ST_IDLE;
            ST_WR_A:  if (tick) state_d = ST_WR_B;
            ST_WR_B:  if (tick) state_d = ST_WR_C;
            ST_WR_C:  if (tick) state_d = ST_WR_D;
            ST_WR_D:  if (tick) state_d = ST_IDLE;
            ST_RD_A:  if (tick) state_d = ST_RD_B;
            ST_RD_B:  if (tick) state_d = ST_RD_C;
            ST_RD_C:  if (tick) state_d = ST_RD_D;
            ST_RD_D:  if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (lost_now) begin
            state_d = ST_IDLE;
            accept  = 1'b0;
        end
    end

    // Outputs and flags, registered from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_rel_q  <= 1'b1;
            sda_rel_q  <= 1'b1;
            tx_q       <= 1'b0;
            ack_q      <= 1'b0;
            rx_q       <= 1'b0;
            busy_q     <= 1'b0;
            lost_q     <= 1'b0;
            stop_exp_q <= 1'b0;
        end else begin
            ack_q <= in_last_phase && tick && !lost_now;
            if (accept) tx_q <= tx_bit;
            if ((state_q == ST_RD_B) && tick) rx_q <= sda_s;

            if (lost_now)    lost_q <= 1'b1;
            else if (accept) lost_q <= 1'b0;

            if (accept && (cmd_e == BC_STOP)) stop_exp_q <= 1'b1;
            else if (start_det)               stop_exp_q <= 1'b0;

            if (start_det)     busy_q <= 1'b1;
            else if (stop_det) busy_q <= 1'b0;

            unique case (state_d)
                ST_IDLE: if (lost_now) begin
                    scl_rel_q <= 1'b1;
                    sda_rel_q <= 1'b1;
                end
                ST_STA_A: sda_rel_q <= 1'b1;
                ST_STA_B: begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b1; end
                ST_STA_C: begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b0; end
                ST_STA_D: begin scl_rel_q <= 1'b0; sda_rel_q <= 1'b0; end
                ST_STP_A: begin scl_rel_q <= 1'b0; sda_rel_q <= 1'b0; end
                ST_STP_B: begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b0; end
                ST_STP_C: begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b1; end
                ST_STP_D: begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b1; end
                ST_WR_A:  begin scl_rel_q <= 1'b0; sda_rel_q <= tx_now; end
                ST_WR_B:  begin scl_rel_q <= 1'b1; sda_rel_q <= tx_now; end
                ST_WR_C:  begin scl_rel_q <= 1'b1; sda_rel_q <= tx_now; end
                ST_WR_D:  begin scl_rel_q <= 1'b0; sda_rel_q <= tx_now; end
                ST_RD_A:  begin scl_rel_q <= 1'b0; sda_rel_q <= 1'b1; end
                ST_RD_B:  begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b1; end
                ST_RD_C:  begin scl_rel_q <= 1'b1; sda_rel_q <= 1'b1; end
                ST_RD_D:  begin scl_rel_q <= 1'b0; sda_rel_q <= 1'b1; end
                default: ;
            endcase
        end
    end

    assign scl_o    = 1'b0;
    assign sda_o    = 1'b0;
    assign scl_oe_n = scl_rel_q;
    assign sda_oe_n = sda_rel_q;
    assign cmd_ack  = ack_q;
    assign rx_bit   = rx_q;
    assign bus_busy = busy_q;
    assign arb_lost = lost_q;

    // R2: completion is a single-cycle pulse
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);

    // R2: completion only follows a final phase
    assert_ack_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(in_last_phase));

    // R5: data line steady while the clock is released in a write
    assert_write_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WR_B) || (state_q == ST_WR_C)) |-> $stable(sda_rel_q));

    // R7: no line movement while disabled
    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(scl_rel_q) && $stable(sda_rel_q)));

    // R9: a lost bus is let go at once
    assert_release_on_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> (scl_rel_q && sda_rel_q));

endmodule

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] prescale = 16'd2;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        tx_bit = 1'b0;
    logic        ext_sda = 1'b1;
    logic        slave_sda = 1'b1;
    logic        cmd_ack, rx_bit, scl_o, scl_oe_n, sda_o, sda_oe_n, bus_busy, arb_lost;
    logic        scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    logic scl_prev_rel = 1'b1;
    logic busy_exp = 1'b0;

    always #2 clk = ~clk;

    // Pulled-up wired-AND bus
    assign scl_line = scl_oe_n ? 1'b1 : scl_o;
    assign sda_line = (sda_oe_n ? 1'b1 : sda_o) & ext_sda & slave_sda;

    i2c_bit_engine u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .cmd_valid(cmd_valid), .cmd(cmd), .tx_bit(tx_bit),
        .scl_in(scl_line), .sda_in(sda_line),
        .cmd_ack(cmd_ack), .rx_bit(rx_bit), .scl_o(scl_o), .scl_oe_n(scl_oe_n),
        .sda_o(sda_o), .sda_oe_n(sda_oe_n), .bus_busy(bus_busy), .arb_lost(arb_lost)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {clock release, data release} per command and phase
    function automatic logic [1:0] exp_lines(input logic [1:0] c, input logic t,
                                             input int ph, input logic prev_scl);
        case (c)
            2'd0: case (ph) 0: return {prev_scl, 1'b1}; 1: return 2'b11;
                            2: return 2'b10; default: return 2'b00; endcase
            2'd1: case (ph) 0: return 2'b00; 1: return 2'b10;
                            default: return 2'b11; endcase
            2'd2: return {(ph == 1 || ph == 2), t};
            default: return {(ph == 1 || ph == 2), 1'b1};
        endcase
    endfunction

    function automatic string cmd_tag(input logic [1:0] c);
        case (c)
            2'd0: return "R3 start";
            2'd1: return "R4 stop";
            2'd2: return "R5 write";
            default: return "R6 read";
        endcase
    endfunction

    task automatic run_cmd(input logic [1:0] c, input logic t, input logic [15:0] p,
                           input logic rd_val);
        logic [1:0] e;
        @(negedge clk);
        prescale = p; cmd = c; tx_bit = t; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (c == 2'd3) slave_sda = rd_val;
        for (int ph = 0; ph < 4; ph++) begin
            if (ph > 0) begin
                repeat (int'(p) + 1) @(posedge clk);
                @(negedge clk);
            end
            e = exp_lines(c, t, ph, scl_prev_rel);
            chk({scl_oe_n, sda_oe_n} == e, cmd_tag(c), {scl_oe_n, sda_oe_n}, e);
            chk(!scl_o && !sda_o, "R11 drive value", {scl_o, sda_o}, 0);
            if (ph == 3) chk(cmd_ack == 1'b0, "R2 ack early", cmd_ack, 0);
        end
        scl_prev_rel = e[1];
        slave_sda = 1'b1;
        repeat (int'(p) + 1) @(posedge clk);
        @(negedge clk);
        chk(cmd_ack == 1'b1, "R2 ack timing", cmd_ack, 1);
        chk(arb_lost == 1'b0, "R10 arb cleared", arb_lost, 0);
        if (c == 2'd3) chk(rx_bit == rd_val, "R6 rx bit", rx_bit, rd_val);
        if (c == 2'd0) busy_exp = 1'b1;
        if (c == 2'd1) busy_exp = 1'b0;
        chk(bus_busy == busy_exp, "R8 busy", bus_busy, busy_exp);
        @(posedge clk);
        @(negedge clk);
        chk(cmd_ack == 1'b0, "R2 ack width", cmd_ack, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        int acks;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe_n && sda_oe_n, "R1 lines released", {scl_oe_n, sda_oe_n}, 3);
        chk(!cmd_ack && !rx_bit, "R1 ack/rx low", {cmd_ack, rx_bit}, 0);
        chk(!bus_busy && !arb_lost, "R1 flags low", {bus_busy, arb_lost}, 0);

        // R7: command ignored while disabled
        cmd = 2'd0; cmd_valid = 1'b1;
        acks = 0;
        repeat (12) begin
            @(negedge clk);
            if (cmd_ack) acks++;
            if (!scl_oe_n || !sda_oe_n) acks += 100;
        end
        cmd_valid = 1'b0;
        chk(acks == 0, "R7 disabled ignores command", acks, 0);
        enable = 1'b1;

        // Directed patterns
        run_cmd(2'd0, 1'b0, 16'd2, 1'b1);
        run_cmd(2'd2, 1'b0, 16'd2, 1'b1);
        run_cmd(2'd2, 1'b1, 16'd2, 1'b1);
        run_cmd(2'd3, 1'b0, 16'd2, 1'b0);
        run_cmd(2'd3, 1'b0, 16'd2, 1'b1);
        run_cmd(2'd1, 1'b0, 16'd2, 1'b1);

        // R8/R10: start and stop made by another master
        @(negedge clk); ext_sda = 1'b0;
        repeat (4) @(negedge clk);
        chk(bus_busy == 1'b1, "R8 foreign start", bus_busy, 1);
        chk(arb_lost == 1'b0, "R10 no loss on start", arb_lost, 0);
        ext_sda = 1'b1;
        repeat (4) @(negedge clk);
        chk(arb_lost == 1'b1, "R10 foreign stop", arb_lost, 1);
        chk(bus_busy == 1'b0, "R8 foreign stop", bus_busy, 0);

        // R9: loss in the same cycle as the phase C tick
        run_cmd(2'd0, 1'b0, 16'd3, 1'b1);
        @(negedge clk);
        prescale = 16'd3; cmd = 2'd2; tx_bit = 1'b1; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (9) @(posedge clk);
        @(negedge clk);
        ext_sda = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(arb_lost == 1'b0 && scl_oe_n, "R9 still in phase C", {arb_lost, scl_oe_n}, 1);
        @(posedge clk);
        @(negedge clk);
        chk(arb_lost == 1'b1, "R9 loss flagged", arb_lost, 1);
        chk(scl_oe_n && sda_oe_n, "R9 lines released", {scl_oe_n, sda_oe_n}, 3);
        acks = 0;
        repeat (8) begin
            @(negedge clk);
            if (cmd_ack) acks++;
        end
        chk(acks == 0, "R9 no ack after loss", acks, 0);
        ext_sda = 1'b1;
        repeat (4) @(negedge clk);
        chk(bus_busy == 1'b0, "R8 busy after release", bus_busy, 0);
        scl_prev_rel = 1'b1;
        busy_exp = 1'b0;

        // Random command stream
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  c;
            logic [15:0] p;
            c = 2'($urandom % 4);
            p = 16'(1 + $urandom % 5);
            run_cmd(c, 1'($urandom % 2), p, 1'($urandom % 2));
        end

        finish_run();
    end

endmodule